// File: doc/BRIEF.md
# Timer Clock Select and Prescaler

This block turns a 3-bit source code into the count-enable pulse of an 8-bit timer. The code chooses among three kinds of source. Code 000 is the stopped state. Codes 001 to 101 tap a free-running binary prescaler at fixed ratios of 1, 8, 64, 256 and 1024 system clocks. Codes 110 and 111 count falling or rising edges on an external input pin. The tick is a pulse in the system clock domain that the timer counter uses as its clock enable.

The external pin is asynchronous. It passes through a two-flop synchronizer. A further flop keeps the previous synchronized level, and the edge detector compares the two. The prescaler is never cleared by a change of code. After a switch, the first tick therefore arrives when the new tap next fires, which can be earlier than one full period.

The block has an asynchronous active-low reset that is released synchronously to the system clock. The counter and the compare logic that use the tick are outside this block.

Top module: `tmr_clk_select`

## Requirements
- R1: While the source code is 000, the tick output is 0 in every cycle, whatever the external pin does.
- R2: With code 001 the tick output is 1 in every cycle.
- R3: With code 010 the tick is a single-cycle pulse repeating every 8 system clocks.
- R4: With code 011 the tick is a single-cycle pulse repeating every 64 system clocks.
- R5: With code 100 the tick is a single-cycle pulse repeating every 256 system clocks.
- R6: With code 101 the tick is a single-cycle pulse repeating every 1024 system clocks.
- R7: With code 110, each high-to-low transition of the external pin gives exactly one tick, 2 to 3 system clocks after the pin changes.
- R8: With code 111, each low-to-high transition of the external pin gives exactly one tick, 2 to 3 system clocks after the pin changes.
- R9: In the two external modes, a pin transition of the polarity that is not selected gives no tick.
- R10: A change of code does not clear the prescaler. After 64-way operation and then three 8-way ticks, returning to code 011 gives the next tick 40 clocks after the last 8-way tick, not 64.
- R11: In the external modes, a pin that toggles on every system clock gives one tick for each selected edge, and no tick lasts longer than one cycle.
- R12: While reset is asserted, the tick is 0 for code 010, because the prescaler is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Source code: 000 stop, 001 to 101 prescaled, 110 falling pin edge, 111 rising pin edge |
| ext_pin_i | input | 1 | External count pin, asynchronous to clk_i |
| tick_o | output | 1 | Count-enable pulse for the timer |

## Verification
Two events can land in the same cycle: a change of source code, and a prescaler tap that belongs to a different ratio. The 64-way tap always fires on a cycle where the 8-way tap also fires. The bench provokes this in two steps. It first locks onto a 64-way tick, switches to code 010 and counts three 8-way ticks. It then switches back to code 011 in the cycle right after the third of them. The result is judged by the exact distance to the next tick: 40 clocks shows that the shared counter kept its phase, and any other value shows that it was cleared or disturbed.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    CS_OFF      = 3'b000,
    CS_DIV1     = 3'b001,
    CS_DIV8     = 3'b010,
    CS_DIV64    = 3'b011,
    CS_DIV256   = 3'b100,
    CS_DIV1024  = 3'b101,
    CS_EXT_FALL = 3'b110,
    CS_EXT_RISE = 3'b111
  } clk_sel_e;

  localparam int unsigned NUM_TAPS = 4;

endpackage

// File: rtl/tcs_rst_sync.sv
// Reset is asserted asynchronously and released on a clock edge.
module tcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_no = stage_q[STAGES-1];

endmodule

// File: rtl/tcs_prescaler.sv
// Free-running binary divider. Each tap is high for one cycle
// when its low-order bits are all ones.
module tcs_prescaler
  import tcs_pkg::*;
#(
  parameter int unsigned LOG_A = 3,
  parameter int unsigned LOG_B = 6,
  parameter int unsigned LOG_C = 8,
  parameter int unsigned LOG_D = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] tap_o
);

  localparam int unsigned CNT_W = LOG_D;
  localparam int unsigned TAP_LOG [NUM_TAPS] = '{LOG_A, LOG_B, LOG_C, LOG_D};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_o[g] = &cnt_q[TAP_LOG[g]-1:0];
  end

endmodule

// File: rtl/tcs_edge_det.sv
// Synchronizer chain for the asynchronous pin, followed by a
// one-flop history used to detect transitions.
module tcs_edge_det #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_N-1:0] sh_q;
  logic [SYNC_N-1:0] sh_d;
  logic              last_q;
  logic              last_d;
  logic              lvl;

  assign lvl = sh_q[SYNC_N-1];

  always_comb begin
    sh_d   = {sh_q[SYNC_N-2:0], pin_i};
    last_d = lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= last_d;
    end
  end

  assign rise_o = lvl & ~last_q;
  assign fall_o = ~lvl & last_q;

endmodule

// File: rtl/tcs_tick_sel.sv
// Chooses the count-enable source from the 3-bit code.
module tcs_tick_sel
  import tcs_pkg::*;
(
  input  logic [2:0]          sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                tick_o
);

  always_comb begin
    case (clk_sel_e'(sel_i))
      CS_OFF:      tick_o = 1'b0;
      CS_DIV1:     tick_o = 1'b1;
      CS_DIV8:     tick_o = tap_i[0];
      CS_DIV64:    tick_o = tap_i[1];
      CS_DIV256:   tick_o = tap_i[2];
      CS_DIV1024:  tick_o = tap_i[3];
      CS_EXT_FALL: tick_o = fall_i;
      CS_EXT_RISE: tick_o = rise_i;
      default:     tick_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_clk_select.sv
module tmr_clk_select
  import tcs_pkg::*;
#(
  parameter int unsigned PRE_LOG_A  = 3,
  parameter int unsigned PRE_LOG_B  = 6,
  parameter int unsigned PRE_LOG_C  = 8,
  parameter int unsigned PRE_LOG_D  = 10,
  parameter int unsigned SYNC_N     = 2,
  parameter int unsigned RST_SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_pin_i,
  output logic       tick_o
);

  logic                rst_int_n;
  logic [NUM_TAPS-1:0] taps;
  logic                pin_rise;
  logic                pin_fall;

  tcs_rst_sync #(
    .STAGES(RST_SYNC_N)
  ) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_int_n)
  );

  tcs_prescaler #(
    .LOG_A(PRE_LOG_A),
    .LOG_B(PRE_LOG_B),
    .LOG_C(PRE_LOG_C),
    .LOG_D(PRE_LOG_D)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .tap_o (taps)
  );

  tcs_edge_det #(
    .SYNC_N(SYNC_N)
  ) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .pin_i (ext_pin_i),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  tcs_tick_sel u_sel (
    .sel_i (sel_i),
    .tap_i (taps),
    .rise_i(pin_rise),
    .fall_i(pin_fall),
    .tick_o(tick_o)
  );

endmodule

// File: rtl/tmr_clk_select_chk.sv
module tmr_clk_select_chk #(
  parameter int unsigned LOG_A = 3,
  parameter int unsigned LOG_B = 6,
  parameter int unsigned LOG_C = 8,
  parameter int unsigned LOG_D = 10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] sel_i,
  input logic       ext_pin_i,
  input logic       tick_o
);

  localparam int unsigned GW = LOG_D + 2;

  function automatic logic [GW-1:0] ratio_of(input logic [2:0] s);
    case (s)
      3'b010:  return GW'(1) << LOG_A;
      3'b011:  return GW'(1) << LOG_B;
      3'b100:  return GW'(1) << LOG_C;
      3'b101:  return GW'(1) << LOG_D;
      default: return '0;
    endcase
  endfunction

  function automatic logic is_presc(input logic [2:0] s);
    return (s >= 3'b010) && (s <= 3'b101);
  endfunction

  logic [GW-1:0] gap_q;
  logic [2:0]    tsel_q;
  logic          same_q;
  logic [2:0]    up_q;

  // gap_q: cycles since the previous tick. same_q: the code has not
  // changed since that tick. up_q: cycles since reset, saturating.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      tsel_q <= '0;
      same_q <= 1'b0;
      up_q   <= '0;
    end else begin
      if (up_q != 3'd7) up_q <= up_q + 3'd1;
      if (tick_o) begin
        gap_q  <= GW'(1);
        tsel_q <= sel_i;
        same_q <= 1'b1;
      end else begin
        if (gap_q != '1) gap_q <= gap_q + GW'(1);
        if (sel_i != tsel_q) same_q <= 1'b0;
      end
    end
  end

  p_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b000) |-> !tick_o);

  p_div1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b001) |-> tick_o);

  // Covers R3 to R6: in every prescaled mode the spacing between ticks equals the ratio.
  p_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && same_q && is_presc(sel_i) && sel_i == tsel_q) |-> (gap_q == ratio_of(sel_i)));

  p_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && is_presc(sel_i)) |=> (!tick_o || sel_i != $past(sel_i)));

  p_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b110 && tick_o && up_q == 3'd7) |-> (!$past(ext_pin_i, 2) && $past(ext_pin_i, 3)));

  p_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b111 && tick_o && up_q == 3'd7) |-> ($past(ext_pin_i, 2) && !$past(ext_pin_i, 3)));

  p_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[2:1] == 2'b11 && tick_o) |=> (!tick_o || sel_i != $past(sel_i)));

endmodule

bind tmr_clk_select tmr_clk_select_chk #(
  .LOG_A(PRE_LOG_A),
  .LOG_B(PRE_LOG_B),
  .LOG_C(PRE_LOG_C),
  .LOG_D(PRE_LOG_D)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .ext_pin_i(ext_pin_i),
  .tick_o   (tick_o)
);

// File: tb/tmr_clk_select_tb_top.sv
module tmr_clk_select_tb_top;

  logic       clk;
  logic       rst_n;
  logic [2:0] sel;
  logic       pin;
  logic       tick;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  tmr_clk_select dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sel_i    (sel),
    .ext_pin_i(pin),
    .tick_o   (tick)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  // R12: prescaled code held during reset gives no tick
  task automatic t_reset();
    int n = 0;
    rst_n = 1'b0; sel = 3'b010; pin = 1'b0;
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (tick) n++;
    end
    chk(n == 0, "R12", n, 0, "ticks during reset");
    sel = 3'b000;
    rst_n = 1'b1;
    repeat (4) cyc();
  endtask

  // R1: stop code blocks every source, including a toggling pin
  task automatic t_stop();
    int n = 0;
    sel = 3'b001;
    cyc();
    sel = 3'b000;
    for (int i = 0; i < 40; i++) begin
      pin = i[1];
      cyc();
      if (tick) n++;
    end
    pin = 1'b0;
    chk(n == 0, "R1", n, 0, "ticks in stop mode");
  endtask

  task automatic t_div1();
    int n = 0;
    sel = 3'b001;
    for (int i = 0; i < 16; i++) begin
      cyc();
      if (tick) n++;
    end
    chk(n == 16, "R2", n, 16, "ticks in 16 cycles");
  endtask

  task automatic t_div(input logic [2:0] code, input int ratio, input string req);
    int w = 0;
    sel = code;
    do begin
      cyc();
      w++;
    end while (!tick && w < ratio + 4);
    chk(tick == 1'b1, req, w, ratio, "first tick wait");
    for (int k = 0; k < 3; k++) begin
      int gap = 0;
      do begin
        cyc();
        gap++;
      end while (!tick && gap < ratio + 4);
      chk(gap == ratio, req, gap, ratio, "tick spacing");
    end
  endtask

  // R7/R8 with R9: ignored polarity first, then the selected one
  task automatic t_ext(input bit rising, input string req);
    int n = 0;
    int lat = 0;
    sel = rising ? 3'b111 : 3'b110;
    pin = rising;
    repeat (6) cyc();
    pin = ~rising;
    for (int i = 0; i < 6; i++) begin
      cyc();
      if (tick) n++;
    end
    chk(n == 0, "R9", n, 0, "ticks from unselected edge");
    n = 0;
    pin = rising;
    for (int i = 1; i <= 6; i++) begin
      cyc();
      if (tick) begin
        n++;
        if (lat == 0) lat = i;
      end
    end
    chk(n == 1, req, n, 1, "ticks per selected edge");
    chk(lat >= 2 && lat <= 3, req, lat, 2, "edge to tick latency");
  endtask

  // R11: pin toggling every clock, ten rising edges
  task automatic t_burst();
    int n = 0;
    sel = 3'b111;
    pin = 1'b0;
    repeat (6) cyc();
    for (int i = 0; i < 10; i++) begin
      pin = 1'b1;
      cyc();
      if (tick) n++;
      pin = 1'b0;
      cyc();
      if (tick) n++;
    end
    for (int i = 0; i < 4; i++) begin
      cyc();
      if (tick) n++;
    end
    chk(n == 10, "R11", n, 10, "ticks for toggling pin");
  endtask

  // R10: prescaler phase survives code changes
  task automatic t_phase();
    int w = 0;
    int seen = 0;
    int el = 0;
    sel = 3'b011;
    do begin
      cyc();
      w++;
    end while (!tick && w < 70);
    chk(tick == 1'b1, "R10", w, 64, "lock on 64-way tick");
    sel = 3'b010;
    while (seen < 3 && el < 40) begin
      cyc();
      el++;
      if (tick) seen++;
    end
    chk(el == 24, "R10", el, 24, "three 8-way ticks");
    sel = 3'b011;
    w = 0;
    do begin
      cyc();
      w++;
    end while (!tick && w < 80);
    chk(w == 40, "R10", w, 40, "first tick after switch back");
  endtask

  initial begin
    t_reset();
    t_stop();
    t_div1();
    t_div(3'b010, 8, "R3");
    t_div(3'b011, 64, "R4");
    t_div(3'b100, 256, "R5");
    t_div(3'b101, 1024, "R6");
    t_ext(1'b0, "R7");
    t_ext(1'b1, "R8");
    t_burst();
    t_phase();
    sel = 3'b000;
    cyc();
    chk(tick == 1'b0, "R1", tick, 0, "tick after return to stop");
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    report();
  end

endmodule